// File: doc/BRIEF.md
# Three-Phase PWM Gate Output Stage

This block produces the six gate drive lines of a three-phase half-bridge inverter: one high-side and one low-side line for each of phases A, B and C. A shared up-counter sets the switching period, and one compare value per phase sets its on-time. An external commutation source chooses which arms may conduct. A per-arm modulation select then decides whether each enabled arm follows the phase PWM or is held steadily on.

The arm signals pass through a fixed chain. Each line first gets its own dead-time delay on its rising edge. Next comes a shutdown stage that latches on an external fault or on a detected high/low overlap and forces every line to its idle level. Last comes a per-line polarity inversion, so that the block can drive active-high or active-low gate drivers. Software configures the block through a single-cycle parallel write port.

Top module: `pwm3_gate_stage`

## Requirements
- R1: The counter runs from 0 up to the active period and then returns to 0. A write to address 0 loads a pending period, which becomes active only on the cycle in which the counter returns to 0. After reset the period is 2^CNT_W-1 and all gate outputs are low.
- R2: Addresses 1, 2 and 3 load the pending duty for phases A, B and C. A pending duty becomes active only when the counter returns to 0. While the active duty D satisfies 0 < D < period, the phase PWM is high exactly while count < D.
- R3: An active duty of 0 holds the phase PWM low for the whole period. An active duty greater than or equal to the active period holds it high for the whole period.
- R4: `arm_en` and `gate_o` use the bit order AH, AL, BH, BL, CH, CL (bit 0 to bit 5). Address 4 bits [5:0] are the per-arm modulation selects in the same order. An arm with `arm_en` low is off. An enabled arm with its select set follows the PWM. An enabled arm with its select clear is held on.
- R5: Address 4 bit 6 selects complementary mode. In this mode a modulated low-side arm follows the inverse of its phase PWM. Otherwise it follows the PWM itself.
- R6: Address 5 bits [DT_W-1:0] set the dead time N. The rising edge of an arm is delayed by N clock cycles beyond its normal latency, and a falling edge is not delayed.
- R7: The high and low outputs of one phase are never active in the same cycle. If both arms of a phase become active after the dead-time stage, all outputs go idle in that cycle and the shutdown latch sets.
- R8: A high `fault_in` sets the shutdown latch and idles all outputs from the next cycle. The latch stays set until a write to address 7 clears it, and a fault that arrives together with the clear write wins.
- R9: Address 6 bits [5:0] invert each output, in the bit order of R4. An idle output equals its polarity bit. An output goes from the arm signal to a gate line two clock cycles after the counter value that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| arm_en | input | 6 | Per-arm enables from the commutation source |
| fault_in | input | 1 | External fault request |
| gate_o | output | 6 | Gate lines AH, AL, BH, BL, CH, CL after polarity |

## Verification
The assertions assume that the inputs are free of X after reset and that reset is held for at least one clock. This lets the past polarity value and the counter-within-period check start from the known reset state. They place no limit on the register values, because period, duty and dead time may take any value. The stimulus keeps periods small so that shadow loads happen often. It writes random duties just above and below the period, and random arm enables that at times request both arms of a phase. It raises rare random faults and issues clear writes, so the shutdown and overlap paths are exercised under many configurations.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NUM_PH  = 3;
  localparam int NUM_ARM = 2 * NUM_PH;

  typedef enum logic [2:0] {
    RA_PERIOD = 3'd0,
    RA_DUTY_A = 3'd1,
    RA_DUTY_B = 3'd2,
    RA_DUTY_C = 3'd3,
    RA_ARMCTL = 3'd4,
    RA_DEAD   = 3'd5,
    RA_POL    = 3'd6,
    RA_CLEAR  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wd,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] PER_RST = '1;

  logic [CNT_W-1:0] cnt_q, per_act_q, per_pend_q;
  logic             wrap;

  assign wrap = (cnt_q == per_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      per_act_q  <= PER_RST;
      per_pend_q <= PER_RST;
    end else begin
      if (per_we) per_pend_q <= per_wd;
      if (wrap) begin
        cnt_q     <= '0;
        per_act_q <= per_pend_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_act_q;
  assign wrap_o = wrap;

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_act_q);
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);
  a_r1_period_shadow: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(per_act_q));
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             duty_we,
  input  logic [CNT_W-1:0] duty_wd,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             en_hi,
  input  logic             en_lo,
  input  logic             mod_hi,
  input  logic             mod_lo,
  input  logic             comp_i,
  output logic             raw_hi_o,
  output logic             raw_lo_o
);
  logic [CNT_W-1:0] duty_act_q, duty_pend_q;
  logic             pwm, lo_wave;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act_q  <= '0;
      duty_pend_q <= '0;
    end else begin
      if (duty_we) duty_pend_q <= duty_wd;
      if (wrap_i)  duty_act_q  <= duty_pend_q;
    end
  end

  always_comb begin
    if (duty_act_q == '0)        pwm = 1'b0;
    else if (duty_act_q >= per_i) pwm = 1'b1;
    else                          pwm = (cnt_i < duty_act_q);
  end

  assign lo_wave  = comp_i ? ~pwm : pwm;
  assign raw_hi_o = en_hi & (mod_hi ? pwm : 1'b1);
  assign raw_lo_o = en_lo & (mod_lo ? lo_wave : 1'b1);

  a_r2_duty_shadow: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(duty_act_q));
  a_r5_comp_exclusive: assert property (@(posedge clk) disable iff (rst)
    (comp_i && mod_hi && mod_lo) |-> !(raw_hi_o && raw_lo_o));
endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DT_W-1:0] dt_i,
  input  logic            x_i,
  output logic            y_o
);
  logic [DT_W-1:0] wait_q;
  logic            y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0;
      y_q    <= 1'b0;
    end else if (!x_i) begin
      wait_q <= '0;
      y_q    <= 1'b0;
    end else if (wait_q >= dt_i) begin
      y_q <= 1'b1;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign y_o = y_q;

  a_r6_fall_immediate: assert property (@(posedge clk) disable iff (rst)
    !x_i |=> !y_q);
  a_r6_rise_needs_input: assert property (@(posedge clk) disable iff (rst)
    $rose(y_q) |-> $past(x_i));
endmodule

// File: rtl/pwm3_gate_stage.sv
module pwm3_gate_stage #(
  parameter int CNT_W  = 10,
  parameter int DT_W   = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [5:0]        arm_en,
  input  logic              fault_in,
  output logic [5:0]        gate_o
);
  import pwm3_pkg::*;

  localparam int CMP_BIT = NUM_ARM;

  logic [CNT_W-1:0]   cnt, per;
  logic               wrap;
  logic [NUM_ARM-1:0] mod_q, pol_q, raw, dly, gate_q;
  logic               comp_q, flt_q, clr_we, shoot, kill;
  logic [DT_W-1:0]    dt_q;
  logic [NUM_PH-1:0]  pair_on;

  assign clr_we = wr_en && (wr_addr == RA_CLEAR);

  pwm3_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst),
    .per_we(wr_en && (wr_addr == RA_PERIOD)),
    .per_wd(wr_data[CNT_W-1:0]),
    .cnt_o(cnt), .per_o(per), .wrap_o(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q  <= '0;
      comp_q <= 1'b0;
      dt_q   <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_ARMCTL: begin
          mod_q  <= wr_data[NUM_ARM-1:0];
          comp_q <= wr_data[CMP_BIT];
        end
        RA_DEAD: dt_q  <= wr_data[DT_W-1:0];
        RA_POL:  pol_q <= wr_data[NUM_ARM-1:0];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    pwm3_phase #(.CNT_W(CNT_W)) u_ph (
      .clk(clk), .rst(rst),
      .duty_we(wr_en && (wr_addr == 3'(p + 1))),
      .duty_wd(wr_data[CNT_W-1:0]),
      .wrap_i(wrap), .cnt_i(cnt), .per_i(per),
      .en_hi(arm_en[2*p]), .en_lo(arm_en[2*p+1]),
      .mod_hi(mod_q[2*p]), .mod_lo(mod_q[2*p+1]),
      .comp_i(comp_q),
      .raw_hi_o(raw[2*p]), .raw_lo_o(raw[2*p+1])
    );
    assign pair_on[p] = dly[2*p] & dly[2*p+1];

    a_r7_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
      !((gate_o[2*p] ^ $past(pol_q[2*p])) && (gate_o[2*p+1] ^ $past(pol_q[2*p+1]))));
  end

  for (genvar a = 0; a < NUM_ARM; a++) begin : g_arm
    pwm3_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst(rst), .dt_i(dt_q), .x_i(raw[a]), .y_o(dly[a])
    );
  end

  assign shoot = |pair_on;
  assign kill  = flt_q | fault_in | shoot;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q  <= 1'b0;
      gate_q <= '0;
    end else begin
      flt_q  <= (flt_q & ~clr_we) | fault_in | shoot;
      gate_q <= kill ? pol_q : (dly ^ pol_q);
    end
  end

  assign gate_o = gate_q;

  a_r8_fault_idles: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> gate_o == $past(pol_q));
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (flt_q && !clr_we) |=> flt_q);
  a_r7_overlap_latches: assert property (@(posedge clk) disable iff (rst)
    shoot |=> flt_q);
endmodule

// File: tb/tb_pwm3_gate_stage.sv
`timescale 1ns/1ps
module tb_pwm3_gate_stage;
  localparam int CNT_W = 10, DT_W = 6, DATA_W = 16;

  logic              clk = 1'b0, rst = 1'b1, wr_en = 1'b0, fault_in = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [5:0]        arm_en = '0;
  logic [5:0]        gate_o;

  pwm3_gate_stage #(.CNT_W(CNT_W), .DT_W(DT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arm_en(arm_en), .fault_in(fault_in), .gate_o(gate_o)
  );

  always #10 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int         m_cnt, m_per, m_perp, m_dt;
  int         m_duty[3], m_dutyp[3], m_dtc[6];
  logic [5:0] m_mod, m_pol, m_dtq, m_gate;
  logic       m_cmp, m_flt;

  function automatic logic ref_pwm(int cnt, int per, int duty);
    if (duty == 0) return 1'b0;
    if (duty >= per) return 1'b1;
    return cnt < duty;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per = 1023; m_perp = 1023; m_dt = 0;
      m_mod = '0; m_pol = '0; m_dtq = '0; m_gate = '0; m_cmp = 0; m_flt = 0;
      for (int i = 0; i < 3; i++) begin m_duty[i] = 0; m_dutyp[i] = 0; end
      for (int i = 0; i < 6; i++) m_dtc[i] = 0;
    end else begin
      logic [5:0] raw;
      logic shoot, pw;
      for (int p = 0; p < 3; p++) begin
        pw = ref_pwm(m_cnt, m_per, m_duty[p]);
        raw[2*p]   = arm_en[2*p]   & (m_mod[2*p]   ? pw : 1'b1);
        raw[2*p+1] = arm_en[2*p+1] & (m_mod[2*p+1] ? (m_cmp ? ~pw : pw) : 1'b1);
      end
      shoot = (m_dtq[0] & m_dtq[1]) | (m_dtq[2] & m_dtq[3]) | (m_dtq[4] & m_dtq[5]);
      m_gate = (m_flt | fault_in | shoot) ? m_pol : (m_dtq ^ m_pol);
      m_flt = (m_flt & !(wr_en && wr_addr == 3'd7)) | fault_in | shoot;
      for (int i = 0; i < 6; i++) begin
        if (!raw[i]) begin m_dtq[i] = 0; m_dtc[i] = 0; end
        else if (m_dtc[i] >= m_dt) m_dtq[i] = 1;
        else m_dtc[i]++;
      end
      if (m_cnt == m_per) begin
        m_cnt = 0; m_per = m_perp;
        for (int i = 0; i < 3; i++) m_duty[i] = m_dutyp[i];
      end else m_cnt++;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_perp = int'(wr_data[CNT_W-1:0]);
          3'd1, 3'd2, 3'd3: m_dutyp[wr_addr-1] = int'(wr_data[CNT_W-1:0]);
          3'd4: begin m_mod = wr_data[5:0]; m_cmp = wr_data[6]; end
          3'd5: m_dt = int'(wr_data[DT_W-1:0]);
          3'd6: m_pol = wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (gate_o !== m_gate) begin
        n_bad++;
        $display("FAIL %s: gate_o actual %b expected %b at %0t", cur_req, gate_o, m_gate, $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic wr(logic [2:0] a, int d);
    wr_en = 1; wr_addr = a; wr_data = DATA_W'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic check_idle(string req, int n);
    repeat (n) begin
      @(negedge clk); #1;
      n_vec++;
      if (gate_o !== m_pol) begin
        n_bad++;
        $display("FAIL %s: idle gate_o actual %b expected %b", req, gate_o, m_pol);
      end
      @(posedge clk); #5;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    cur_req = "R1";
    run(3); @(posedge clk); #5; rst = 0;
    // R1: reset period, then shorter period taking effect at wrap
    arm_en = 6'b000001;
    wr(3'd4, 6'b000001);
    wr(3'd1, 300);
    run(1100);
    wr(3'd0, 9); wr(3'd1, 4);
    run(1100);
    wr(3'd0, 5);
    run(40);
    // R2: duty changes mid period
    cur_req = "R2";
    wr(3'd2, 3); arm_en = 6'b000101; wr(3'd4, 6'b000101);
    run(4); wr(3'd1, 2); run(30);
    // R3: duty zero, equal and above period
    cur_req = "R3";
    wr(3'd1, 0); wr(3'd2, 5); wr(3'd3, 40); arm_en = 6'b010101;
    wr(3'd4, 6'b010101); run(30);
    // R4: mask and enable combinations
    cur_req = "R4";
    wr(3'd1, 3); arm_en = 6'b011001; wr(3'd4, 6'b000001); run(25);
    arm_en = 6'b000010; wr(3'd4, 6'b000000); run(10);
    // R5: complementary lower arm
    cur_req = "R5";
    wr(3'd0, 11); arm_en = 6'b111111; wr(3'd4, 7'b1111111);
    wr(3'd1, 4); wr(3'd2, 7); wr(3'd3, 11); run(50);
    // R6: dead time values
    cur_req = "R6";
    wr(3'd5, 3); run(50); wr(3'd5, 7); run(50); wr(3'd5, 0); run(30);
    // R9: polarity per output
    cur_req = "R9";
    wr(3'd6, 6'b101101); run(40);
    // R7: overlap request latches shutdown
    cur_req = "R7";
    arm_en = 6'b000011; wr(3'd4, 0); run(3);
    check_idle("R7", 8);
    arm_en = 6'b000001; wr(3'd7, 1); run(20);
    // R8: fault latch held until clear
    cur_req = "R8";
    wr(3'd4, 6'b000001); run(10);
    fault_in = 1; tick(); fault_in = 0;
    check_idle("R8", 6);
    wr(3'd1, 2); check_idle("R8", 6);
    fault_in = 1; wr(3'd7, 1); fault_in = 0;
    check_idle("R8", 4);
    wr(3'd7, 1); run(30);
    wr(3'd6, 0);
    // mixed random traffic
    cur_req = "R4";
    for (int it = 0; it < 400; it++) begin
      int per;
      per = 3 + int'($urandom_range(0, 27));
      case (it % 4)
        0: cur_req = "R2";
        1: cur_req = "R5";
        2: cur_req = "R6";
        default: cur_req = "R9";
      endcase
      wr(3'd0, per);
      for (int k = 1; k <= 3; k++) wr(3'(k), int'($urandom_range(0, per + 3)));
      wr(3'd4, int'($urandom_range(0, 127)));
      wr(3'd5, int'($urandom_range(0, 5)));
      wr(3'd6, int'($urandom_range(0, 63)));
      arm_en = 6'($urandom_range(0, 63));
      wr(3'd7, 1);
      for (int c = 0; c < 60; c++) begin
        fault_in = ($urandom_range(0, 199) == 0);
        tick();
      end
      fault_in = 0;
    end
    run(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule